// File: doc/BRIEF.md
# Three-Tier Call-Frame Spill Engine

This block keeps the operand state of nested call frames for a processor core, with no program instruction taking part. Live operands that functional units must give up land in a small pool of flip-flop holding registers that software cannot address. Those registers form the active frame. A call copies the active frame into a private frame store, one word per cycle, and the callee then starts with an empty pool. A return brings the caller's frame back. The frame store is a ring of fixed-size slots. When a call finds every slot full, the oldest resident frame is first written out through a request/response port to the next-level cache. A return whose frame is no longer resident refills it from that port. All such traffic goes to a private address region with its own tag, so it never overlaps program data.

Each process has its own frame depth and its own field in the spill address. A task switch saves the active frame, flushes every resident frame of the old process to the cache, and then fetches the top frame of the incoming process, if that process has one.

The controller has five states. ST_IDLE accepts events and parks. ST_EVICT writes the oldest slot to the cache. ST_SAVE copies the active frame into the head slot. ST_RESTORE copies the newest slot back. ST_FILL reads a frame from the cache. The transitions are as follows. IDLE goes to EVICT on a call or switch with the store full, to SAVE on a call or switch with room, to RESTORE on a return with a resident frame, and to FILL on a return without one. EVICT goes to SAVE after a pre-call eviction. During a switch flush, EVICT goes back to EVICT while slots remain, then to FILL or IDLE. SAVE goes to IDLE after a call, or to EVICT to begin a switch flush. RESTORE and FILL go back to IDLE.

Top module: `spill_engine`

## Requirements
- R1: After reset, busy is 0, no cache request is raised, process 0 is active at depth 0, and every holding register reads 0.
- R2: A park in ST_IDLE writes park_data into the register at park_idx, and unpark_data shows it at that index from the next cycle onward. A park while busy is ignored.
- R3: While no event arrives, busy stays 0 and l2_req_valid stays 0.
- R4: A call at depth below MAX_DEPTH with a free slot holds busy for exactly FRAME_WORDS cycles. Afterwards every holding register reads 0.
- R5: A return whose caller frame is resident holds busy for exactly FRAME_WORDS cycles, issues no cache request, and restores every word of that frame.
- R6: A call with all NSLOTS slots full first issues exactly FRAME_WORDS cache writes of the oldest frame. Each write has l2_req_addr = {REGION_TAG, pid, frame depth index, word index}, from the most significant field down, where the depth index counts frames from the bottom of that process's stack starting at 0.
- R7: A return whose frame is not resident reads it back from the cache with l2_req_write = 0 and holds busy until every word has arrived.
- R8: A return at depth 0 is ignored, and so is a call at depth MAX_DEPTH. Neither raises busy, and the holding registers are unchanged.
- R9: A task switch stores the active frame and all resident frames under the old pid, then makes the new process current. If that process has a saved frame, its top frame is restored into the holding registers. If not, the registers read 0. A switch at depth MAX_DEPTH is ignored.
- R10: When events coincide, a switch wins over a call and a call wins over a return. Events arriving while busy are ignored.
- R11: A cache request held without l2_req_ready keeps l2_req_valid, the address, the direction and the write data stable until it is accepted.
- R12: Call and return runs deeper than NSLOTS return every frame in last-in first-out order with every operand intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| park_valid | input | 1 | Park an operand |
| park_idx | input | WORD_AW | Holding register index |
| park_data | input | DATA_W | Operand value to park |
| unpark_idx | input | WORD_AW | Holding register to read |
| unpark_data | output | DATA_W | Value of that register |
| call_evt | input | 1 | Call event |
| ret_evt | input | 1 | Return event |
| switch_evt | input | 1 | Task switch event |
| switch_pid | input | PID_W | Incoming process number |
| busy | output | 1 | A transfer is in progress |
| l2_req_valid | output | 1 | Cache request valid |
| l2_req_ready | input | 1 | Cache accepts request |
| l2_req_write | output | 1 | 1 for write, 0 for read |
| l2_req_addr | output | ADDR_W | Spill-region address |
| l2_req_wdata | output | DATA_W | Write data |
| l2_resp_valid | input | 1 | Read data valid, in request order |
| l2_resp_data | input | DATA_W | Read data |

FRAME_WORDS, NSLOTS and MAX_DEPTH are powers of two.

## Verification
The bench pushes frames past the slot count and down to MAX_DEPTH, then unwinds them and compares every word. A wrong ring pointer or a wrong depth index in the spill address would therefore hand back the wrong frame or a stale one. It also checks the exact busy length for resident calls and returns, and the number of cache writes on a full call. A design that traded a cheap eviction for a missing one, or that drifted in word count, would fail those counts. Coincident events, and parks or calls sent while busy, are used to expose wrong priority or writes that leak into a restore. Switches between processes, including a switch back to a process that holds saved frames, check that flushing and per-process depth bookkeeping survive the round trip, with cache ready stalls applied all along.

// File: rtl/spill_pkg.sv
package spill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_SAVE,
        ST_RESTORE,
        ST_FILL
    } spill_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CALL,
        OP_RET,
        OP_SWITCH
    } spill_op_t;

endpackage

// File: rtl/spill_operand_bank.sv
module spill_operand_bank #(
    parameter int DATA_W = 32,
    parameter int NWORDS = 4,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_en,
    input  logic [IDX_W-1:0]  park_idx,
    input  logic [DATA_W-1:0] park_data,
    input  logic              bulk_en,
    input  logic [IDX_W-1:0]  bulk_idx,
    input  logic [DATA_W-1:0] bulk_data,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] regs_q [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (clear) begin
                regs_q[i] <= '0;
            end else if (bulk_en && bulk_idx == IDX_W'(i)) begin
                regs_q[i] <= bulk_data;
            end else if (park_en && park_idx == IDX_W'(i)) begin
                regs_q[i] <= park_data;
            end
        end
    end

    assign rd_a_data = regs_q[rd_a_idx];
    assign rd_b_data = regs_q[rd_b_idx];

    // R2: the park path and the internal transfer path never write in the same cycle
    a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(park_en && (bulk_en || clear)));

endmodule

// File: rtl/spill_frame_sram.sv
module spill_frame_sram #(
    parameter int DATA_W = 32,
    parameter int NENTRIES = 16,
    parameter int AW = $clog2(NENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [NENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spill_slot_ring.sv
module spill_slot_ring #(
    parameter int NSLOTS = 4,
    parameter int SLOT_W = $clog2(NSLOTS),
    parameter int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              drop,
    output logic [SLOT_W-1:0] head_slot,
    output logic [SLOT_W-1:0] top_slot,
    output logic [SLOT_W-1:0] tail_slot,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    logic [SLOT_W-1:0] head_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                head_q <= head_q + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end else if (pop) begin
                head_q <= head_q - 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end else if (drop) begin
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign head_slot = head_q;
    assign top_slot  = head_q - 1'b1;
    assign tail_slot = head_q - SLOT_W'(cnt_q);
    assign count     = cnt_q;
    assign full      = (cnt_q == CNT_W'(NSLOTS));

    // R6: a frame is never pushed into a full ring
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: restore and eviction only take frames that are resident
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || drop) |-> (cnt_q != '0));
    // R12: at most one ring operation per cycle
    a_r12_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop, drop}));

endmodule

// File: rtl/spill_engine.sv
module spill_engine
    import spill_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FRAME_WORDS = 4,
    parameter int NSLOTS      = 4,
    parameter int MAX_DEPTH   = 16,
    parameter int NPROC       = 4,
    parameter int TAG_W       = 4,
    parameter logic [TAG_W-1:0] REGION_TAG = 4'hC,
    localparam int WORD_AW = $clog2(FRAME_WORDS),
    localparam int DEPTH_W = $clog2(MAX_DEPTH),
    localparam int PID_W   = $clog2(NPROC),
    localparam int ADDR_W  = TAG_W + PID_W + DEPTH_W + WORD_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               park_valid,
    input  logic [WORD_AW-1:0] park_idx,
    input  logic [DATA_W-1:0]  park_data,
    input  logic [WORD_AW-1:0] unpark_idx,
    output logic [DATA_W-1:0]  unpark_data,
    input  logic               call_evt,
    input  logic               ret_evt,
    input  logic               switch_evt,
    input  logic [PID_W-1:0]   switch_pid,
    output logic               busy,
    output logic               l2_req_valid,
    input  logic               l2_req_ready,
    output logic               l2_req_write,
    output logic [ADDR_W-1:0]  l2_req_addr,
    output logic [DATA_W-1:0]  l2_req_wdata,
    input  logic               l2_resp_valid,
    input  logic [DATA_W-1:0]  l2_resp_data
);

    localparam int SLOT_W  = $clog2(NSLOTS);
    localparam int CNT_W   = SLOT_W + 1;
    localparam int SRAM_AW = SLOT_W + WORD_AW;
    localparam logic [WORD_AW-1:0] LAST_WORD = WORD_AW'(FRAME_WORDS - 1);
    localparam logic [DEPTH_W:0]   DEPTH_CAP = (DEPTH_W + 1)'(MAX_DEPTH);

    spill_state_t state_q, state_d;
    spill_op_t    op_q, start_op, evt_op;
    logic         flush_q;
    logic [WORD_AW-1:0] wcnt_q;
    logic [WORD_AW:0]   issue_q;
    logic [DEPTH_W:0]   depth_q;
    logic [PID_W-1:0]   pid_q, next_pid_q;
    logic [DEPTH_W:0]   depth_tab_q [NPROC];

    logic [SLOT_W-1:0] head_slot, top_slot, tail_slot;
    logic [CNT_W-1:0]  ring_cnt;
    logic              ring_full, ring_push, ring_pop, ring_drop;

    logic              bank_park_en, bank_bulk_en, bank_clear;
    logic [DATA_W-1:0] bank_bulk_data, bank_rd_b_data;
    logic              sram_we;
    logic [SRAM_AW-1:0] sram_waddr, sram_raddr;
    logic [DATA_W-1:0] sram_rdata;

    logic word_adv, issue_adv, depth_inc, depth_dec, switch_done, set_flush;
    logic room, have_frame;
    logic [DEPTH_W-1:0] evict_idx, fill_idx;
    logic [DEPTH_W:0]   new_depth;

    // ---------------------------------------------------------------
    // Storage tiers
    // ---------------------------------------------------------------
    spill_operand_bank #(.DATA_W(DATA_W), .NWORDS(FRAME_WORDS), .IDX_W(WORD_AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .park_en   (bank_park_en),
        .park_idx  (park_idx),
        .park_data (park_data),
        .bulk_en   (bank_bulk_en),
        .bulk_idx  (wcnt_q),
        .bulk_data (bank_bulk_data),
        .clear     (bank_clear),
        .rd_a_idx  (unpark_idx),
        .rd_a_data (unpark_data),
        .rd_b_idx  (wcnt_q),
        .rd_b_data (bank_rd_b_data)
    );

    spill_frame_sram #(.DATA_W(DATA_W), .NENTRIES(NSLOTS * FRAME_WORDS), .AW(SRAM_AW)) u_sram (
        .clk   (clk),
        .we    (sram_we),
        .waddr (sram_waddr),
        .wdata (bank_rd_b_data),
        .raddr (sram_raddr),
        .rdata (sram_rdata)
    );

    spill_slot_ring #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .pop       (ring_pop),
        .drop      (ring_drop),
        .head_slot (head_slot),
        .top_slot  (top_slot),
        .tail_slot (tail_slot),
        .count     (ring_cnt),
        .full      (ring_full)
    );

    // ---------------------------------------------------------------
    // Event decode and address fields
    // ---------------------------------------------------------------
    assign room       = (depth_q < DEPTH_CAP);
    assign have_frame = (depth_q != '0);
    assign evict_idx  = DEPTH_W'(depth_q - (DEPTH_W + 1)'(ring_cnt));
    assign fill_idx   = DEPTH_W'(depth_q - 1'b1);
    assign new_depth  = (next_pid_q == pid_q) ? depth_q : depth_tab_q[next_pid_q];

    always_comb begin
        evt_op = OP_NONE;
        if (switch_evt) begin
            if (room) evt_op = OP_SWITCH;
        end else if (call_evt) begin
            if (room) evt_op = OP_CALL;
        end else if (ret_evt) begin
            if (have_frame) evt_op = OP_RET;
        end
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // Next state and outputs
    // ---------------------------------------------------------------
    always_comb begin
        state_d        = state_q;
        start_op       = OP_NONE;
        bank_park_en   = 1'b0;
        bank_bulk_en   = 1'b0;
        bank_bulk_data = '0;
        bank_clear     = 1'b0;
        sram_we        = 1'b0;
        sram_waddr     = {head_slot, wcnt_q};
        sram_raddr     = {tail_slot, wcnt_q};
        ring_push      = 1'b0;
        ring_pop       = 1'b0;
        ring_drop      = 1'b0;
        word_adv       = 1'b0;
        issue_adv      = 1'b0;
        depth_inc      = 1'b0;
        depth_dec      = 1'b0;
        switch_done    = 1'b0;
        set_flush      = 1'b0;
        l2_req_valid   = 1'b0;
        l2_req_write   = 1'b0;
        l2_req_addr    = '0;
        l2_req_wdata   = '0;

        unique case (state_q)
            ST_IDLE: begin
                bank_park_en = park_valid;
                start_op     = evt_op;
                unique case (evt_op)
                    OP_CALL, OP_SWITCH: state_d = ring_full ? ST_EVICT : ST_SAVE;
                    OP_RET:             state_d = (ring_cnt != '0) ? ST_RESTORE : ST_FILL;
                    default:            state_d = ST_IDLE;
                endcase
            end
            ST_EVICT: begin
                sram_raddr   = {tail_slot, wcnt_q};
                l2_req_valid = 1'b1;
                l2_req_write = 1'b1;
                l2_req_addr  = {REGION_TAG, pid_q, evict_idx, wcnt_q};
                l2_req_wdata = sram_rdata;
                if (l2_req_ready) begin
                    word_adv = 1'b1;
                    if (wcnt_q == LAST_WORD) begin
                        ring_drop = 1'b1;
                        if (!flush_q) begin
                            state_d = ST_SAVE;
                        end else if (ring_cnt == CNT_W'(1)) begin
                            switch_done = 1'b1;
                            state_d     = (new_depth != '0) ? ST_FILL : ST_IDLE;
                        end
                    end
                end
            end
            ST_SAVE: begin
                sram_we    = 1'b1;
                sram_waddr = {head_slot, wcnt_q};
                word_adv   = 1'b1;
                if (wcnt_q == LAST_WORD) begin
                    ring_push  = 1'b1;
                    bank_clear = 1'b1;
                    depth_inc  = 1'b1;
                    if (op_q == OP_SWITCH) begin
                        set_flush = 1'b1;
                        state_d   = ST_EVICT;
                    end else begin
                        state_d   = ST_IDLE;
                    end
                end
            end
            ST_RESTORE: begin
                sram_raddr     = {top_slot, wcnt_q};
                bank_bulk_en   = 1'b1;
                bank_bulk_data = sram_rdata;
                word_adv       = 1'b1;
                if (wcnt_q == LAST_WORD) begin
                    ring_pop  = 1'b1;
                    depth_dec = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_FILL: begin
                l2_req_valid = !issue_q[WORD_AW];
                l2_req_addr  = {REGION_TAG, pid_q, fill_idx, issue_q[WORD_AW-1:0]};
                issue_adv    = l2_req_valid && l2_req_ready;
                if (l2_resp_valid) begin
                    bank_bulk_en   = 1'b1;
                    bank_bulk_data = l2_resp_data;
                    word_adv       = 1'b1;
                    if (wcnt_q == LAST_WORD) begin
                        depth_dec = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // ---------------------------------------------------------------
    // Counters, depth and process bookkeeping
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            flush_q    <= 1'b0;
            wcnt_q     <= '0;
            issue_q    <= '0;
            depth_q    <= '0;
            pid_q      <= '0;
            next_pid_q <= '0;
            for (int i = 0; i < NPROC; i++) depth_tab_q[i] <= '0;
        end else begin
            if (start_op != OP_NONE) begin
                op_q <= start_op;
                if (start_op == OP_SWITCH) next_pid_q <= switch_pid;
            end
            if (word_adv) wcnt_q <= wcnt_q + 1'b1;
            if (issue_adv) issue_q <= issue_q + 1'b1;
            if (depth_dec && state_q == ST_FILL) issue_q <= '0;
            if (set_flush) flush_q <= 1'b1;
            if (depth_inc) begin
                depth_q <= depth_q + 1'b1;
            end else if (depth_dec) begin
                depth_q <= depth_q - 1'b1;
            end else if (switch_done) begin
                depth_q <= new_depth;
            end
            if (switch_done) begin
                depth_tab_q[pid_q] <= depth_q;
                pid_q              <= next_pid_q;
                flush_q            <= 1'b0;
            end
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    // R3: no cache traffic unless a transfer is running
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !l2_req_valid);
    // R11: a stalled request holds still
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && !l2_req_ready) |=> (l2_req_valid && $stable(l2_req_addr)
            && $stable(l2_req_write) && $stable(l2_req_wdata)));
    // R8: depth never passes its ceiling
    a_r8_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_CAP);
    // R7: a refill only reads
    a_r7_fill_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && l2_req_valid) |-> !l2_req_write);
    // R4: a save leaves the callee an empty, non-busy frame only after the last word
    a_r4_save_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE && op_q == OP_CALL && wcnt_q == LAST_WORD) |=> !busy);

endmodule

// File: tb/spill_engine_test.sv
`timescale 1ns/1ps
module spill_engine_test;

    localparam int FW    = 4;
    localparam int NS    = 4;
    localparam int MAXD  = 16;
    localparam int NP    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        park_valid = 1'b0;
    logic [1:0]  park_idx = '0;
    logic [31:0] park_data = '0;
    logic [1:0]  unpark_idx = '0;
    logic [31:0] unpark_data;
    logic        call_evt = 1'b0, ret_evt = 1'b0, switch_evt = 1'b0;
    logic [1:0]  switch_pid = '0;
    logic        busy;
    logic        l2_req_valid, l2_req_write;
    logic        l2_req_ready;
    logic [11:0] l2_req_addr;
    logic [31:0] l2_req_wdata;
    logic        l2_resp_valid;
    logic [31:0] l2_resp_data;

    always #4 clk = ~clk;

    spill_engine uut (
        .clk(clk), .rst_n(rst_n),
        .park_valid(park_valid), .park_idx(park_idx), .park_data(park_data),
        .unpark_idx(unpark_idx), .unpark_data(unpark_data),
        .call_evt(call_evt), .ret_evt(ret_evt), .switch_evt(switch_evt), .switch_pid(switch_pid),
        .busy(busy),
        .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready), .l2_req_write(l2_req_write),
        .l2_req_addr(l2_req_addr), .l2_req_wdata(l2_req_wdata),
        .l2_resp_valid(l2_resp_valid), .l2_resp_data(l2_resp_data)
    );

    // ---------------- cache model and port monitor ----------------
    logic [31:0] l2_mem [0:4095];
    int cyc_ctr = 0, l2_acc = 0, l2_writes = 0, tag_bad = 0, hold_bad = 0;
    int quiet_bad = 0;
    logic hold_pend = 1'b0;
    logic [11:0] hold_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            l2_req_ready  <= 1'b0;
            l2_resp_valid <= 1'b0;
            l2_resp_data  <= '0;
            hold_pend     <= 1'b0;
        end else begin
            cyc_ctr       <= cyc_ctr + 1;
            l2_req_ready  <= (cyc_ctr % 5) != 3;
            l2_resp_valid <= 1'b0;
            if (hold_pend && (!l2_req_valid || l2_req_addr !== hold_addr)) hold_bad <= hold_bad + 1;
            if (!busy && l2_req_valid) quiet_bad <= quiet_bad + 1;
            hold_pend <= l2_req_valid && !l2_req_ready;
            hold_addr <= l2_req_addr;
            if (l2_req_valid && l2_req_ready) begin
                l2_acc <= l2_acc + 1;
                if (l2_req_addr[11:8] != 4'hC) tag_bad <= tag_bad + 1;
                if (l2_req_write) begin
                    l2_mem[l2_req_addr] <= l2_req_wdata;
                    l2_writes <= l2_writes + 1;
                end else begin
                    l2_resp_valid <= 1'b1;
                    l2_resp_data  <= l2_mem[l2_req_addr];
                end
            end
        end
    end

    // ---------------- reference model ----------------
    int m_stack [NP][MAXD][FW];
    int m_depth [NP];
    int m_cur [FW];
    int m_pid = 0;
    int m_cnt = 0;
    bit m_evict;
    bit m_resident;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_frame(input string req);
        for (int w = 0; w < FW; w++) begin
            @(negedge clk);
            unpark_idx = w[1:0];
            #1;
            chk(req, unpark_data, m_cur[w]);
        end
    endtask

    task automatic park_frame(input int seed);
        for (int w = 0; w < FW; w++) begin
            @(negedge clk);
            park_valid = 1'b1;
            park_idx   = w[1:0];
            park_data  = 32'h5A00_0000 + seed * 16 + w;
            m_cur[w]   = 32'h5A00_0000 + seed * 16 + w;
        end
        @(negedge clk);
        park_valid = 1'b0;
    endtask

    // returns expected busy cycles, -1 when not fixed
    function automatic int model_evt(input bit c, input bit r, input bit s, input int p);
        int d;
        d = m_depth[m_pid];
        m_evict = 1'b0;
        m_resident = 1'b0;
        if (s) begin
            if (d >= MAXD) return 0;
            for (int w = 0; w < FW; w++) m_stack[m_pid][d][w] = m_cur[w];
            m_depth[m_pid] = d + 1;
            m_cnt = 0;
            m_pid = p;
            if (m_depth[p] > 0) begin
                m_depth[p]--;
                for (int w = 0; w < FW; w++) m_cur[w] = m_stack[p][m_depth[p]][w];
            end else begin
                for (int w = 0; w < FW; w++) m_cur[w] = 0;
            end
            return -1;
        end else if (c) begin
            if (d >= MAXD) return 0;
            for (int w = 0; w < FW; w++) m_stack[m_pid][d][w] = m_cur[w];
            for (int w = 0; w < FW; w++) m_cur[w] = 0;
            m_depth[m_pid] = d + 1;
            if (m_cnt == NS) begin
                m_evict = 1'b1;
                return -1;
            end
            m_cnt++;
            return FW;
        end else if (r) begin
            if (d == 0) return 0;
            m_depth[m_pid] = d - 1;
            for (int w = 0; w < FW; w++) m_cur[w] = m_stack[m_pid][d - 1][w];
            if (m_cnt > 0) begin
                m_cnt--;
                m_resident = 1'b1;
                return FW;
            end
            return -1;
        end
        return 0;
    endfunction

    task automatic run_evt(input bit c, input bit r, input bit s, input int p, input string req);
        int exp_cyc;
        int cyc;
        int w0;
        int a0;
        exp_cyc = model_evt(c, r, s, p);
        w0 = l2_writes;
        a0 = l2_acc;
        @(negedge clk);
        call_evt = c; ret_evt = r; switch_evt = s; switch_pid = p[1:0];
        @(negedge clk);
        call_evt = 1'b0; ret_evt = 1'b0; switch_evt = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
        if (exp_cyc >= 0) chk({req, " busy cycles"}, cyc, exp_cyc);
        if (m_evict) chk("R6 eviction write count", l2_writes - w0, FW);
        if (m_resident) chk("R5 no cache traffic on resident return", l2_acc - a0, 0);
        check_frame(req);
    endtask

    // op: 1 park(seed) 2 call 3 return 4 switch(pid) 5 call+return 6 switch+call
    localparam int NV = 34;
    localparam logic [11:0] VEC [NV] = '{
        12'h101, 12'h200, 12'h102, 12'h200, 12'h103, 12'h200, 12'h104, 12'h200,
        12'h105, 12'h200, 12'h106, 12'h200, 12'h300, 12'h300, 12'h300, 12'h300,
        12'h300, 12'h300, 12'h300, 12'h107, 12'h200, 12'h108, 12'h401, 12'h109,
        12'h200, 12'h400, 12'h300, 12'h401, 12'h300, 12'h10A, 12'h500, 12'h300,
        12'h602, 12'h400
    };

    initial begin
        for (int i = 0; i < NP; i++) m_depth[i] = 0;
        for (int w = 0; w < FW; w++) m_cur[w] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 no request after reset", l2_req_valid, 0);
        check_frame("R1 registers zero after reset");
        // R3 quiet while idle
        repeat (10) @(negedge clk);
        chk("R3 idle stays quiet", busy | l2_req_valid, 0);
        // R2 park and read back
        park_frame(0);
        check_frame("R2 park readback");
        // R8 return at depth 0
        run_evt(1'b0, 1'b1, 1'b0, 0, "R8 return at depth zero");

        // table walk: R4 R5 R6 R7 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][11:8])
                4'h1: park_frame(int'(VEC[i][7:0]));
                4'h2: run_evt(1'b1, 1'b0, 1'b0, 0, "R4 call");
                4'h3: run_evt(1'b0, 1'b1, 1'b0, 0, "R5 R7 return");
                4'h4: run_evt(1'b0, 1'b0, 1'b1, int'(VEC[i][1:0]), "R9 switch");
                4'h5: run_evt(1'b1, 1'b1, 1'b0, 0, "R10 call beats return");
                4'h6: run_evt(1'b1, 1'b0, 1'b1, int'(VEC[i][1:0]), "R10 switch beats call");
                default: ;
            endcase
        end

        // R12 deep run to the ceiling and back
        begin
            int seed = 32;
            while (m_depth[m_pid] < MAXD) begin
                park_frame(seed);
                seed++;
                run_evt(1'b1, 1'b0, 1'b0, 0, "R12 deep call");
            end
            park_frame(seed);
        end
        run_evt(1'b1, 1'b0, 1'b0, 0, "R8 call at ceiling");
        run_evt(1'b0, 1'b0, 1'b1, 1, "R9 switch at ceiling");
        while (m_depth[m_pid] > 0) run_evt(1'b0, 1'b1, 1'b0, 0, "R12 deep return");

        // R10 / R2: parks and a call while a restore is running
        park_frame(90);
        run_evt(1'b1, 1'b0, 1'b0, 0, "R4 call before busy test");
        park_frame(91);
        begin
            int dummy;
            dummy = model_evt(1'b0, 1'b1, 1'b0, 0);
            @(negedge clk);
            ret_evt = 1'b1;
            @(negedge clk);
            ret_evt = 1'b0;
            call_evt = 1'b1;
            park_valid = 1'b1;
            park_idx = 2'd0;
            park_data = 32'hDEAD_BEEF;
            while (busy) @(negedge clk);
            call_evt = 1'b0;
            park_valid = 1'b0;
            chk("R10 call while busy ignored", busy, 0);
            check_frame("R2 park while busy ignored");
        end

        chk("R11 stalled request held", hold_bad, 0);
        chk("R6 spill address tag", tag_bad, 0);
        chk("R3 no request while idle", quiet_bad, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule